// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects interrupt requests from eight peripherals and presents one active-high interrupt line to a processor. A rising edge on a request input, after synchronisation, is stored as a pending request unless that input is masked. The lowest-numbered pending input wins. It raises the interrupt line only when no level of equal or higher priority is still being serviced.

The processor answers with a one-cycle acknowledge strobe. In that cycle the block drives a type number on its vector output: a base of 8 plus the winning input's index, with a valid flag. The winning request then moves from pending to in-service. Software ends service by writing an end-of-interrupt command byte to register location 0. This releases the most urgent in-service level. Register location 1 holds the mask. Reading location 0 returns the pending bits.

Top module: `irqc`

## Requirements
- R1: After reset no request is pending or in service, all eight mask bits read back as 1, and `int_o` is low.
- R2: A rising edge on `irq_i[i]` with mask bit i clear shows as pending bit i no later than the third clock edge after the rise. Several inputs can be pending at once.
- R3: The mask register sits at location 1 (`addr_i`=1) and reads back what was written. Bit i = 1 disables input i, and a rising edge on a masked input is not latched.
- R4: Priority is fixed: among pending inputs the lowest index is served first (input 0 highest, input 7 lowest).
- R5: `int_o` is high exactly when some request is pending and no in-service bit has an index less than or equal to the highest-priority pending index.
- R6: When `ack_i` is high while `int_o` is high, `vec_o` equals 8 plus the winning index and `vec_valid_o` is 1 in that same cycle. When `ack_i` is high while `int_o` is low, `vec_valid_o` is 0 and `vec_o` is 0.
- R7: An accepted acknowledge clears the winner's pending bit and sets its in-service bit at the same clock edge.
- R8: Writing 0x20 to location 0 clears the lowest-index set in-service bit. Any other byte written to location 0 has no effect.
- R9: Reading location 0 returns the pending register, with bit i standing for input i. Reads are combinational on `rdata_o`.
- R10: When an accepted acknowledge and an end-of-interrupt fall in the same cycle, both take effect. When a new edge on the winning input falls in the acknowledge cycle, that input stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Request inputs, active high, edge detected |
| int_o | output | 1 | Interrupt line to processor |
| ack_i | input | 1 | One-cycle acknowledge strobe |
| vec_o | output | 8 | Type number during acknowledge |
| vec_valid_o | output | 1 | Qualifies `vec_o` |
| addr_i | input | 1 | Register select: 0 command/pending, 1 mask |
| wr_en_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data |

## Verification
Two functions can land on the same clock edge. The first pair is an acknowledge and an end-of-interrupt write. The bench asserts both strobes in one cycle while an older level is in service. It then judges the result at the ports: the interrupt line must re-arm for that older input, and it must stay blocked for lower inputs. The second pair is an acknowledge and a fresh edge on the winning input. The bench times the input's rise so the pending update lands on the acknowledge edge, then expects the pending bit read back at location 0 to still be set.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int unsigned IRQ_N    = 8;
    localparam int unsigned IDX_W    = $clog2(IRQ_N);
    localparam int unsigned BUS_W    = 8;
    localparam logic [BUS_W-1:0] VEC_BASE = 8'd8;
    localparam logic [BUS_W-1:0] EOI_CMD  = 8'h20;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] rise_o
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [2:0] sh_q;
        logic [2:0] sh_d;
        always_comb begin
            sh_d = {sh_q[1:0], raw_i[g]};
        end
        always_ff @(posedge clk) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= sh_d;
        end
        assign rise_o[g] = sh_q[1] & ~sh_q[2];
    end
endmodule

// File: rtl/irqc_pick.sv
module irqc_pick #(
    parameter int unsigned N = 8,
    localparam int unsigned W = $clog2(N)
) (
    input  logic [N-1:0] req_i,
    output logic         any_o,
    output logic [W-1:0] idx_o,
    output logic [N-1:0] upto_o
);
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                any_o = 1'b1;
                idx_o = W'(i);
            end
        end
        for (int i = 0; i < N; i++) begin
            upto_o[i] = (W'(i) <= idx_o);
        end
    end
endmodule

// File: rtl/irqc.sv
module irqc
    import irqc_pkg::*;
#(
    parameter int unsigned N_IRQ = IRQ_N,
    parameter int unsigned DW    = BUS_W,
    localparam int unsigned IW   = $clog2(N_IRQ)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_i,
    output logic             int_o,
    input  logic             ack_i,
    output logic [DW-1:0]    vec_o,
    output logic             vec_valid_o,
    input  logic             addr_i,
    input  logic             wr_en_i,
    input  logic [DW-1:0]    wdata_i,
    output logic [DW-1:0]    rdata_o
);
    typedef struct packed {
        logic [N_IRQ-1:0] pend;
        logic [N_IRQ-1:0] isr;
        logic [N_IRQ-1:0] mask;
    } state_t;

    state_t st_q, st_d;

    logic [N_IRQ-1:0] rise;
    logic             p_any, s_any;
    logic [IW-1:0]    p_idx, s_idx;
    logic [N_IRQ-1:0] p_upto, s_upto;
    logic             take, eoi;
    logic [N_IRQ-1:0] take_bit, eoi_bit;

    logic [N_IRQ-1:0] pend_q, isr_q, mask_q;
    assign pend_q = st_q.pend;
    assign isr_q  = st_q.isr;
    assign mask_q = st_q.mask;

    irqc_sync #(.N(N_IRQ)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (irq_i),
        .rise_o (rise)
    );

    irqc_pick #(.N(N_IRQ)) u_pick_pend (
        .req_i  (st_q.pend),
        .any_o  (p_any),
        .idx_o  (p_idx),
        .upto_o (p_upto)
    );

    irqc_pick #(.N(N_IRQ)) u_pick_isr (
        .req_i  (st_q.isr),
        .any_o  (s_any),
        .idx_o  (s_idx),
        .upto_o (s_upto)
    );

    always_comb begin
        st_d        = st_q;
        int_o       = p_any && ((st_q.isr & p_upto) == '0);
        take        = ack_i && int_o;
        eoi         = wr_en_i && !addr_i && (wdata_i == DW'(EOI_CMD));
        take_bit    = take ? (N_IRQ'(1) << p_idx) : '0;
        eoi_bit     = (eoi && s_any) ? (N_IRQ'(1) << s_idx) : '0;
        vec_valid_o = take;
        vec_o       = take ? (DW'(VEC_BASE) + DW'(p_idx)) : '0;
        rdata_o     = addr_i ? DW'(st_q.mask) : DW'(st_q.pend);

        // new edges win over the acknowledge clear on the same input
        st_d.pend = (st_q.pend & ~take_bit) | (rise & ~st_q.mask);
        st_d.isr  = (st_q.isr & ~eoi_bit) | take_bit;
        if (wr_en_i && addr_i) begin
            st_d.mask = wdata_i[N_IRQ-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pend <= '0;
            st_q.isr  <= '0;
            st_q.mask <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    logic unused_upto;
    assign unused_upto = ^s_upto;
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int unsigned N_IRQ = 8,
    parameter int unsigned DW    = 8,
    localparam int unsigned IW   = $clog2(N_IRQ)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             int_o,
    input logic             ack_i,
    input logic [DW-1:0]    vec_o,
    input logic             vec_valid_o,
    input logic             addr_i,
    input logic             wr_en_i,
    input logic [DW-1:0]    wdata_i,
    input logic [N_IRQ-1:0] pend_q,
    input logic [N_IRQ-1:0] isr_q,
    input logic [N_IRQ-1:0] mask_q
);
    logic [N_IRQ-1:0] isr_low, pend_low;
    assign isr_low  = isr_q & ~(isr_q - 1'b1);
    assign pend_low = pend_q & ~(pend_q - 1'b1);

    assert_masked_not_latched_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_q & ~$past(pend_q) & $past(mask_q)) == '0));

    assert_int_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> (pend_q != '0) && ((isr_q == '0) || (isr_low > pend_low)));

    assert_vec_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |-> (vec_o >= DW'(8)) && (vec_o < DW'(8 + N_IRQ)) && ack_i);

    assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> isr_q[$past(vec_o[IW-1:0])]);

    assert_isr_grows_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr_q & ~$past(isr_q)) <= 1);

    assert_eoi_drops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !addr_i && wdata_i == 8'h20 && !ack_i && isr_q != '0)
        |=> ($countones(isr_q) + 1 == $countones($past(isr_q))));
endmodule

bind irqc irqc_checker #(.N_IRQ(N_IRQ), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .int_o       (int_o),
    .ack_i       (ack_i),
    .vec_o       (vec_o),
    .vec_valid_o (vec_valid_o),
    .addr_i      (addr_i),
    .wr_en_i     (wr_en_i),
    .wdata_i     (wdata_i),
    .pend_q      (pend_q),
    .isr_q       (isr_q),
    .mask_q      (mask_q)
);

// File: tb/irqc_test.sv
module irqc_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_i = '0;
    logic       int_o;
    logic       ack_i = 1'b0;
    logic [7:0] vec_o;
    logic       vec_valid_o;
    logic       addr_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wdata_i = '0;
    logic [7:0] rdata_o;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    irqc uut (
        .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .int_o(int_o),
        .ack_i(ack_i), .vec_o(vec_o), .vec_valid_o(vec_valid_o),
        .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [7:0] d);
        @(negedge clk);
        addr_i = a;
        #1 d = rdata_o;
    endtask

    task automatic pulse(input logic [7:0] bits);
        @(negedge clk);
        irq_i = irq_i | bits;
        repeat (2) @(negedge clk);
        irq_i = irq_i & ~bits;
        repeat (2) @(negedge clk);
    endtask

    task automatic ack(output logic v, output logic [7:0] vec);
        @(negedge clk);
        ack_i = 1'b1;
        #1 v = vec_valid_o; vec = vec_o;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic int_is(input string tag, input int exp);
        @(negedge clk);
        #1 chk(tag, int'(int_o), exp);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        int_is("R1 int after reset", 0);
        rd(1'b1, d); chk("R1 mask after reset", d, 8'hFF);
        rd(1'b0, d); chk("R1 pending after reset", d, 0);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        pulse(8'h04);
        rd(1'b0, d); chk("R3 masked edge ignored", d, 0);
        int_is("R3 masked int", 0);
        wr(1'b1, 8'h5A); rd(1'b1, d); chk("R3 mask readback", d, 8'h5A);
        wr(1'b1, 8'h00); rd(1'b1, d); chk("R3 mask cleared", d, 0);
    endtask

    task automatic t_basic;
        logic [7:0] d; logic v; logic [7:0] vec;
        pulse(8'h08);
        rd(1'b0, d); chk("R2 R9 pending IR3", d, 8'h08);
        int_is("R5 int raised", 1);
        ack(v, vec);
        chk("R6 valid", v, 1); chk("R6 vector IR3", vec, 11);
        rd(1'b0, d); chk("R7 pending cleared", d, 0);
        int_is("R5 int after ack", 0);
    endtask

    task automatic t_nest;
        logic [7:0] d; logic v; logic [7:0] vec;
        pulse(8'h20);
        int_is("R5 lower blocked by in-service", 0);
        pulse(8'h02);
        int_is("R5 higher passes", 1);
        ack(v, vec); chk("R4 vector IR1", vec, 9);
        rd(1'b0, d); chk("R7 IR5 still pending", d, 8'h20);
        wr(1'b0, 8'h60);
        int_is("R8 other byte ignored", 0);
        wr(1'b0, 8'h20);
        int_is("R8 one eoi leaves IR3 blocking", 0);
        wr(1'b0, 8'h20);
        int_is("R8 second eoi releases IR5", 1);
        ack(v, vec); chk("R6 vector IR5", vec, 13);
        wr(1'b0, 8'h20);
        ack(v, vec); chk("R6 no int no valid", v, 0); chk("R6 no int vec zero", vec, 0);
    endtask

    task automatic t_multi;
        logic [7:0] d; logic v; logic [7:0] vec;
        pulse(8'h50);
        rd(1'b0, d); chk("R2 two pending", d, 8'h50);
        ack(v, vec); chk("R4 IR4 before IR6", vec, 12);
        wr(1'b0, 8'h20);
        ack(v, vec); chk("R4 IR6 next", vec, 14);
        wr(1'b0, 8'h20);
    endtask

    task automatic t_ack_eoi;
        logic v; logic [7:0] vec;
        pulse(8'h80);
        ack(v, vec); chk("R6 vector IR7", vec, 15);
        pulse(8'h01);
        int_is("R5 IR0 over IR7", 1);
        @(negedge clk);
        ack_i = 1'b1; addr_i = 1'b0; wdata_i = 8'h20; wr_en_i = 1'b1;
        #1 chk("R10 vector IR0 in collision", int'(vec_o), 8);
        @(negedge clk);
        ack_i = 1'b0; wr_en_i = 1'b0;
        pulse(8'h10);
        int_is("R10 IR0 now in service blocks IR4", 0);
        wr(1'b0, 8'h20);
        int_is("R10 IR4 released", 1);
        ack(v, vec); chk("R10 IR4 vector", vec, 12);
        pulse(8'h80);
        int_is("R10 IR7 was cleared by collision eoi", 0);
        wr(1'b0, 8'h20);
        int_is("R10 IR7 serviceable", 1);
        ack(v, vec); wr(1'b0, 8'h20);
    endtask

    task automatic t_ack_edge;
        logic [7:0] d; logic v; logic [7:0] vec;
        pulse(8'h40);
        @(negedge clk); irq_i = 8'h40;
        @(negedge clk);
        @(negedge clk);
        ack_i = 1'b1;
        #1 chk("R10 vector IR6", int'(vec_o), 14);
        @(negedge clk);
        ack_i = 1'b0; irq_i = 8'h00;
        rd(1'b0, d); chk("R10 new edge kept pending", d, 8'h40);
        int_is("R5 blocked by own level", 0);
        wr(1'b0, 8'h20);
        ack(v, vec); chk("R10 second IR6", vec, 14);
        wr(1'b0, 8'h20);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_basic();
        t_nest();
        t_multi();
        t_ack_eoi();
        t_ack_edge();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule